// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the configuration header of one PCI endpoint function. Configuration software reaches it with 32-bit reads and writes at a dword address, each write carrying four byte enables. Every byte lane merges the new data through two per-byte masks. One mask lists the bits that software may write. The other lists status bits that are cleared by writing a one to them. Status error bits are set from the function's own logic through a small event input.

The header holds read-only identity words and a command register. It has a 32-bit I/O BAR, a 32-bit memory BAR, a 64-bit prefetchable memory BAR spread over two dwords, and an expansion ROM BAR. Two BAR slots are not implemented. Each BAR's size is a power of two set by a parameter.

The block derives decode enables and masked base addresses from the stored registers. It also pulses a remap request whenever the address map may have moved. A write of all ones to a BAR is a size probe. It stores the size mask, as the merge rule requires, but it does not request a remap.

Top module: `cfg_header_regs`

## Requirements
- R1: After reset, the command and status word reads 0x00000000, the I/O BAR reads 0x00000001, the prefetchable low BAR reads 0x0000000C, the read data output is zero, the remap request is low, both decode enables are low and every base output is zero.
- R2: A write updates only the bytes whose enable is set. In each enabled byte, bits in the writable mask take the new data and all other bits keep their old value. The writable bits are: cache line size (dword 3, byte 0), interrupt line (dword 15, byte 0) and command mask 0x0547. Interrupt pin (dword 15, byte 1) is read-only at 0x01.
- R3: Status bits 31..27 and 24 of dword 1 are set by `stat_evt_i` bits 7..3 and 0. Writing a one to such a bit clears it and writing a zero leaves it. A set event in the same cycle as a clearing write wins.
- R4: No bit is in both the writable mask and the clear-on-one mask. The clear-on-one status bits cannot be set by a write.
- R5: Read data appears on `rdata_o` in the cycle after `rd_en_i` is sampled and holds until the next read.
- R6: With the default 32 MB size, writing 0xFFFFFFFF to the prefetchable low BAR (dword 6) reads back 0xFE00000C. Its low nibble is fixed at 0xC and bits below 25 read zero. The upper half (dword 7) is fully writable.
- R7: With default sizes, an all-ones write reads back as follows: the I/O BAR (dword 4, bit 0 fixed at 1) gives 0xFFFFFF01, the memory BAR (dword 5) gives 0xFFFFF000, and the ROM BAR (dword 12, bit 0 writable enable) gives 0xFFFF0001.
- R8: `remap_req_o` is high for exactly one cycle, the cycle after a write with at least one byte enable that targets dwords 4 to 9 or 12 with data other than 0xFFFFFFFF. It is also high after any write with byte enable 0 set to dword 1. It stays low after other writes.
- R9: A write of 0xFFFFFFFF to a BAR or ROM BAR dword raises no remap request. The same value written to the command register does raise one.
- R10: Command bit 0 drives `io_dec_en_o` and bit 1 drives `mem_dec_en_o`. A base output is zero while its enable is low; the ROM base also needs ROM bit 0. While enabled, each base is its BAR with the read-only low bits removed, including during a size probe.
- R11: Dword 0 reads the identity word 0x0123ABCD and dword 2 reads the class word 0x05000001. Writes to either are ignored.
- R12: The unimplemented BAR dwords 8 and 9 read zero, even after an all-ones write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr_i | input | 4 | Dword address for read or write |
| wr_en_i | input | 1 | Write strobe |
| be_i | input | 4 | Byte enables for the write |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| stat_evt_i | input | 8 | Status event set strobes for status byte 3 |
| io_dec_en_o | output | 1 | I/O decode enable |
| mem_dec_en_o | output | 1 | Memory decode enable |
| io_base_o | output | 32 | I/O BAR base, zero when disabled |
| mem_base_o | output | 32 | 32-bit memory BAR base, zero when disabled |
| pf_base_o | output | 64 | 64-bit prefetchable BAR base, zero when disabled |
| rom_base_o | output | 32 | ROM BAR base, zero unless enabled |
| remap_req_o | output | 1 | One-cycle request to rebuild the address map |

## Verification
A write is sampled at one clock edge. The stored bytes, decode enables and base outputs change at that edge. The remap pulse is high for the whole following cycle and drops after the next edge. Read data comes from the edge that samples `rd_en_i`. The bench drives inputs on falling edges and samples the outputs of interest at the next falling edge, half a cycle after the edge that produced them. The pulse's return to low is checked one falling edge later. For read timing, the bench also samples one falling edge before the capturing edge, to show that the output has not yet moved.

// File: rtl/cfg_hdr_pkg.sv
// Shared constants, types and mask functions for the configuration header.
// Assumes a 16-dword Type-0 header; dword positions follow the standard layout.
package cfg_hdr_pkg;
    localparam int CFG_AW = 4;
    localparam int NDW    = 1 << CFG_AW;

    localparam int IDX_ID     = 0;
    localparam int IDX_CMD    = 1;
    localparam int IDX_CLASS  = 2;
    localparam int IDX_MISC   = 3;
    localparam int IDX_IOBAR  = 4;
    localparam int IDX_MEMBAR = 5;
    localparam int IDX_PFLO   = 6;
    localparam int IDX_PFHI   = 7;
    localparam int IDX_BAR4   = 8;
    localparam int IDX_BAR5   = 9;
    localparam int IDX_SUBSYS = 11;
    localparam int IDX_ROM    = 12;
    localparam int IDX_INTR   = 15;

    typedef logic [CFG_AW-1:0] dw_addr_t;
    typedef logic [31:0]       dword_t;

    // Mask with bits [31:l] set.
    function automatic dword_t hi_mask(input int l);
        return 32'hFFFF_FFFF << l;
    endfunction

    // Writable bits of each dword.
    function automatic dword_t wmask_of(input int idx, input int io_l, input int mem_l,
                                        input int pf_l, input int rom_l);
        case (idx)
            IDX_CMD:    return 32'h0000_0547;
            IDX_MISC:   return 32'h0000_00FF;
            IDX_IOBAR:  return hi_mask(io_l);
            IDX_MEMBAR: return hi_mask(mem_l);
            IDX_PFLO:   return hi_mask(pf_l);
            IDX_PFHI:   return 32'hFFFF_FFFF;
            IDX_ROM:    return hi_mask(rom_l) | 32'h1;
            IDX_INTR:   return 32'h0000_00FF;
            default:    return 32'h0;
        endcase
    endfunction

    // Clear-on-one bits of each dword.
    function automatic dword_t w1c_of(input int idx);
        return (idx == IDX_CMD) ? 32'hF900_0000 : 32'h0;
    endfunction

    // Reset and read-only pattern of each dword.
    function automatic dword_t init_of(input int idx, input dword_t id_w,
                                       input dword_t cls_w, input dword_t sub_w);
        case (idx)
            IDX_ID:     return id_w;
            IDX_CLASS:  return cls_w;
            IDX_IOBAR:  return 32'h0000_0001;
            IDX_PFLO:   return 32'h0000_000C;
            IDX_SUBSYS: return sub_w;
            IDX_INTR:   return 32'h0000_0100;
            default:    return 32'h0;
        endcase
    endfunction
endpackage

// File: rtl/cfg_mask_table.sv
// Constant mask and reset-pattern table, flattened one dword per 32-bit slice.
// Assumes size parameters are below 32 and above the BAR type bits.
module cfg_mask_table
    import cfg_hdr_pkg::*;
#(
    parameter int     IO_L    = 8,
    parameter int     MEM_L   = 12,
    parameter int     PF_L    = 25,
    parameter int     ROM_L   = 16,
    parameter dword_t ID_WORD = 32'h0123_ABCD,
    parameter dword_t CLS_WORD = 32'h0500_0001,
    parameter dword_t SUB_WORD = 32'h0000_0000
) (
    output logic [NDW*32-1:0] wm_flat,
    output logic [NDW*32-1:0] w1c_flat,
    output logic [NDW*32-1:0] init_flat
);
    for (genvar d = 0; d < NDW; d++) begin : g_dw
        assign wm_flat[d*32 +: 32]   = wmask_of(d, IO_L, MEM_L, PF_L, ROM_L);
        assign w1c_flat[d*32 +: 32]  = w1c_of(d);
        assign init_flat[d*32 +: 32] = init_of(d, ID_WORD, CLS_WORD, SUB_WORD);
    end
endmodule

// File: rtl/cfg_merge_lane.sv
// One byte lane: writable-mask merge, then clear-on-one, then event set.
// Assumes masks are disjoint; set strobes are pre-masked by the caller.
module cfg_merge_lane (
    input  logic [7:0] old_i,
    input  logic [7:0] wd_i,
    input  logic [7:0] wm_i,
    input  logic [7:0] w1c_i,
    input  logic       we_i,
    input  logic [7:0] set_i,
    output logic [7:0] nxt_o
);
    logic [7:0] merged;

    // Merge new data, clear marked bits, then apply hardware sets (set wins).
    always_comb begin
        merged = ((old_i & ~wm_i) | (wd_i & wm_i)) & ~(wd_i & w1c_i);
        nxt_o  = (we_i ? merged : old_i) | set_i;
    end
endmodule

// File: rtl/cfg_remap_detect.sv
// Registers a one-cycle remap request for writes that may move the address map.
// Assumes an all-ones data word to a BAR dword is a size probe.
module cfg_remap_detect
    import cfg_hdr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en_i,
    input  dw_addr_t addr_i,
    input  logic [3:0] be_i,
    input  dword_t   wdata_i,
    output logic     remap_o
);
    logic is_bar, is_cmd, probe, hit;

    // Classify the write target and data.
    always_comb begin
        is_bar = (addr_i >= dw_addr_t'(IDX_IOBAR) && addr_i <= dw_addr_t'(IDX_BAR5)) ||
                 (addr_i == dw_addr_t'(IDX_ROM));
        is_cmd = (addr_i == dw_addr_t'(IDX_CMD)) && be_i[0];
        probe  = (wdata_i == 32'hFFFF_FFFF);
        hit    = wr_en_i && (be_i != 4'b0) && ((is_bar && !probe) || is_cmd);
    end

    // Pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) remap_o <= 1'b0;
        else        remap_o <= hit;
    end
endmodule

// File: rtl/cfg_bar_decode.sv
// Turns stored BAR and command values into gated base addresses.
// Assumes the BARs already hold zeros in their non-writable address bits.
module cfg_bar_decode
    import cfg_hdr_pkg::*;
#(
    parameter int IO_L  = 8,
    parameter int MEM_L = 12,
    parameter int PF_L  = 25,
    parameter int ROM_L = 16
) (
    input  logic   io_en_i,
    input  logic   mem_en_i,
    input  dword_t io_bar_i,
    input  dword_t mem_bar_i,
    input  dword_t pf_lo_i,
    input  dword_t pf_hi_i,
    input  dword_t rom_bar_i,
    output dword_t io_base_o,
    output dword_t mem_base_o,
    output logic [63:0] pf_base_o,
    output dword_t rom_base_o
);
    // Strip type bits and gate by the matching decode enable.
    always_comb begin
        io_base_o  = io_en_i  ? (io_bar_i & hi_mask(IO_L))   : '0;
        mem_base_o = mem_en_i ? (mem_bar_i & hi_mask(MEM_L)) : '0;
        pf_base_o  = mem_en_i ? {pf_hi_i, pf_lo_i & hi_mask(PF_L)} : '0;
        rom_base_o = (mem_en_i && rom_bar_i[0]) ? (rom_bar_i & hi_mask(ROM_L)) : '0;
    end
endmodule

// File: rtl/cfg_header_regs.sv
// Top of the configuration header: storage, per-lane merge, read port,
// remap pulse and base decode. Assumes one access per cycle at cfg_addr_i.
module cfg_header_regs
    import cfg_hdr_pkg::*;
#(
    parameter int     IO_L     = 8,
    parameter int     MEM_L    = 12,
    parameter int     PF_L     = 25,
    parameter int     ROM_L    = 16,
    parameter dword_t ID_WORD  = 32'h0123_ABCD,
    parameter dword_t CLS_WORD = 32'h0500_0001,
    parameter dword_t SUB_WORD = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic        wr_en_i,
    input  logic [3:0]  be_i,
    input  logic [31:0] wdata_i,
    input  logic        rd_en_i,
    output logic [31:0] rdata_o,
    input  logic [7:0]  stat_evt_i,
    output logic        io_dec_en_o,
    output logic        mem_dec_en_o,
    output logic [31:0] io_base_o,
    output logic [31:0] mem_base_o,
    output logic [63:0] pf_base_o,
    output logic [31:0] rom_base_o,
    output logic        remap_req_o
);
    logic [NDW*32-1:0] wm_flat, w1c_flat, init_flat;
    dword_t regs [NDW];
    dword_t nxt  [NDW];

    cfg_mask_table #(
        .IO_L(IO_L), .MEM_L(MEM_L), .PF_L(PF_L), .ROM_L(ROM_L),
        .ID_WORD(ID_WORD), .CLS_WORD(CLS_WORD), .SUB_WORD(SUB_WORD)
    ) u_tbl (
        .wm_flat(wm_flat), .w1c_flat(w1c_flat), .init_flat(init_flat)
    );

    for (genvar d = 0; d < NDW; d++) begin : g_dw
        logic sel;
        assign sel = wr_en_i && (cfg_addr_i == dw_addr_t'(d));
        for (genvar b = 0; b < 4; b++) begin : g_lane
            logic [7:0] set_b;
            if (d == IDX_CMD && b == 3) begin : g_evt
                assign set_b = stat_evt_i & w1c_flat[d*32 + 24 +: 8];
            end else begin : g_noevt
                assign set_b = 8'h00;
            end
            cfg_merge_lane u_lane (
                .old_i(regs[d][b*8 +: 8]),
                .wd_i(wdata_i[b*8 +: 8]),
                .wm_i(wm_flat[d*32 + b*8 +: 8]),
                .w1c_i(w1c_flat[d*32 + b*8 +: 8]),
                .we_i(sel && be_i[b]),
                .set_i(set_b),
                .nxt_o(nxt[d][b*8 +: 8])
            );
        end
        // Dword storage with reset to its fixed pattern.
        always_ff @(posedge clk) begin
            if (!rst_n) regs[d] <= init_flat[d*32 +: 32];
            else        regs[d] <= nxt[d];
        end
    end

    // One-cycle registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_o <= '0;
        else if (rd_en_i) rdata_o <= regs[cfg_addr_i];
    end

    cfg_remap_detect u_remap (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(cfg_addr_i),
        .be_i(be_i), .wdata_i(wdata_i), .remap_o(remap_req_o)
    );

    assign io_dec_en_o  = regs[IDX_CMD][0];
    assign mem_dec_en_o = regs[IDX_CMD][1];

    cfg_bar_decode #(.IO_L(IO_L), .MEM_L(MEM_L), .PF_L(PF_L), .ROM_L(ROM_L)) u_dec (
        .io_en_i(io_dec_en_o), .mem_en_i(mem_dec_en_o),
        .io_bar_i(regs[IDX_IOBAR]), .mem_bar_i(regs[IDX_MEMBAR]),
        .pf_lo_i(regs[IDX_PFLO]), .pf_hi_i(regs[IDX_PFHI]), .rom_bar_i(regs[IDX_ROM]),
        .io_base_o(io_base_o), .mem_base_o(mem_base_o),
        .pf_base_o(pf_base_o), .rom_base_o(rom_base_o)
    );
endmodule

// File: rtl/cfg_header_regs_chk.sv
// Property checker for cfg_header_regs, attached by bind below.
// Assumes the same identity word as the bound instance.
module cfg_header_regs_chk
    import cfg_hdr_pkg::*;
#(
    parameter dword_t ID_WORD = 32'h0123_ABCD
) (
    input logic clk,
    input logic rst_n,
    input logic [CFG_AW-1:0] cfg_addr_i,
    input logic wr_en_i,
    input logic [3:0] be_i,
    input logic [31:0] wdata_i,
    input logic rd_en_i,
    input logic [31:0] rdata_o,
    input logic io_dec_en_o,
    input logic mem_dec_en_o,
    input logic [31:0] io_base_o,
    input logic [31:0] mem_base_o,
    input logic [63:0] pf_base_o,
    input logic remap_req_o,
    input logic [NDW*32-1:0] wm_flat,
    input logic [NDW*32-1:0] w1c_flat
);
    // R4
    mask_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wm_flat & w1c_flat) == '0);
    // R8
    remap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remap_req_o |-> $past(wr_en_i));
    // R9
    probe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wdata_i == 32'hFFFF_FFFF && cfg_addr_i != dw_addr_t'(IDX_CMD)) |=> !remap_req_o);
    // R9
    cmd_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && cfg_addr_i == dw_addr_t'(IDX_CMD) && be_i[0]) |=> remap_req_o);
    // R10
    io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_dec_en_o |-> io_base_o == '0);
    // R10
    mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_dec_en_o |-> (mem_base_o == '0 && pf_base_o == '0));
    // R11
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && cfg_addr_i == dw_addr_t'(IDX_ID)) |=> rdata_o == ID_WORD);
endmodule

bind cfg_header_regs cfg_header_regs_chk #(.ID_WORD(ID_WORD)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_addr_i(cfg_addr_i), .wr_en_i(wr_en_i),
    .be_i(be_i), .wdata_i(wdata_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
    .io_dec_en_o(io_dec_en_o), .mem_dec_en_o(mem_dec_en_o),
    .io_base_o(io_base_o), .mem_base_o(mem_base_o), .pf_base_o(pf_base_o),
    .remap_req_o(remap_req_o), .wm_flat(wm_flat), .w1c_flat(w1c_flat)
);

// File: tb/test_cfg_header_regs.sv
// Directed bench for cfg_header_regs: one task per scenario.
module test_cfg_header_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic [7:0]  stat_evt = '0;
    logic        io_dec_en, mem_dec_en, remap_req;
    logic [31:0] io_base, mem_base, rom_base;
    logic [63:0] pf_base;
    logic        last_remap;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [31:0] ID_W  = 32'h0123_ABCD;
    localparam logic [31:0] CLS_W = 32'h0500_0001;

    always #10 clk = ~clk;

    cfg_header_regs i_cfg_header_regs (
        .clk(clk), .rst_n(rst_n), .cfg_addr_i(cfg_addr), .wr_en_i(wr_en), .be_i(be),
        .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata), .stat_evt_i(stat_evt),
        .io_dec_en_o(io_dec_en), .mem_dec_en_o(mem_dec_en), .io_base_o(io_base),
        .mem_base_o(mem_base), .pf_base_o(pf_base), .rom_base_o(rom_base),
        .remap_req_o(remap_req)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d, input logic [3:0] m);
        @(negedge clk);
        cfg_addr = 4'(a); wdata = d; be = m; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; be = '0;
        last_remap = remap_req;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = 4'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 rdata", rdata, 0);
        chk("R1 remap", remap_req, 0);
        chk("R1 dec", {io_dec_en, mem_dec_en}, 0);
        chk("R1 bases", {io_base, mem_base, rom_base}, 0);
        chk("R1 pf", pf_base, 0);
        rd(1, v); chk("R1 cmd", v, 32'h0);
        rd(4, v); chk("R1 iobar", v, 32'h1);
        rd(6, v); chk("R1 pflo", v, 32'hC);
    endtask

    task automatic t_ids();
        logic [31:0] v;
        wr(0, 32'hFFFF_FFFF, 4'hF); chk("R11 no remap", last_remap, 0);
        rd(0, v); chk("R11 id", v, ID_W);
        wr(2, 32'h0, 4'hF);
        rd(2, v); chk("R11 class", v, CLS_W);
    endtask

    task automatic t_merge();
        logic [31:0] v;
        wr(15, 32'h1234_5678, 4'b0001);
        rd(15, v); chk("R2 intr line", v, 32'h0000_0178);
        wr(15, 32'hAAAA_AA99, 4'b0010);
        rd(15, v); chk("R2 intr pin ro", v, 32'h0000_0178);
        wr(3, 32'h1122_3344, 4'hF);
        rd(3, v); chk("R2 cache line", v, 32'h0000_0044);
    endtask

    task automatic t_bar_size();
        logic [31:0] v;
        wr(6, 32'hFFFF_FFFF, 4'hF); chk("R9 pf probe remap", last_remap, 0);
        rd(6, v); chk("R6 pflo size", v, 32'hFE00_000C);
        wr(7, 32'hFFFF_FFFF, 4'hF);
        rd(7, v); chk("R6 pfhi", v, 32'hFFFF_FFFF);
        wr(4, 32'hFFFF_FFFF, 4'hF); chk("R9 io probe remap", last_remap, 0);
        rd(4, v); chk("R7 io size", v, 32'hFFFF_FF01);
        wr(5, 32'hFFFF_FFFF, 4'hF);
        rd(5, v); chk("R7 mem size", v, 32'hFFFF_F000);
        wr(12, 32'hFFFF_FFFF, 4'hF); chk("R9 rom probe remap", last_remap, 0);
        rd(12, v); chk("R7 rom size", v, 32'hFFFF_0001);
        wr(8, 32'hFFFF_FFFF, 4'hF);
        rd(8, v); chk("R12 bar4", v, 32'h0);
        wr(9, 32'hFFFF_FFFF, 4'hF);
        rd(9, v); chk("R12 bar5", v, 32'h0);
    endtask

    task automatic t_remap();
        logic [31:0] v;
        wr(5, 32'h8000_0000, 4'hF); chk("R8 bar write", last_remap, 1);
        @(negedge clk); chk("R8 one cycle", remap_req, 0);
        wr(12, 32'h0001_0000, 4'hF); chk("R8 rom write", last_remap, 1);
        wr(3, 32'h0, 4'hF); chk("R8 misc quiet", last_remap, 0);
        wr(4, 32'h5, 4'b0000); chk("R8 no enables", last_remap, 0);
        rd(4, v); chk("R2 no enables", v, 32'hFFFF_FF01);
        wr(6, 32'h1200_0000, 4'b1000); chk("R8 partial", last_remap, 1);
        rd(6, v); chk("R2 partial bar", v, 32'h1200_000C);
    endtask

    task automatic t_decode();
        logic [31:0] v;
        wr(1, 32'hFFFF_FFFF, 4'b0011); chk("R9 cmd ones remap", last_remap, 1);
        rd(1, v); chk("R2 cmd mask", v, 32'h0000_0547);
        chk("R10 enables", {io_dec_en, mem_dec_en}, 2'b11);
        wr(4, 32'h0000_1200, 4'hF); chk("R10 io base", io_base, 32'h1200);
        wr(5, 32'h8000_0000, 4'hF); chk("R10 mem base", mem_base, 32'h8000_0000);
        wr(6, 32'h4000_0000, 4'hF);
        wr(7, 32'h0000_0001, 4'hF); chk("R10 pf base", pf_base, 64'h1_4000_0000);
        chk("R10 rom off", rom_base, 0);
        wr(12, 32'h0002_0001, 4'hF); chk("R10 rom base", rom_base, 32'h0002_0000);
        wr(6, 32'hFFFF_FFFF, 4'hF); chk("R9 probe enabled", last_remap, 0);
        chk("R10 probe base", pf_base, 64'h1_FE00_0000);
        wr(6, 32'h4000_0000, 4'hF); chk("R8 restore", last_remap, 1);
        wr(1, 32'h0, 4'b0001); chk("R8 cmd write", last_remap, 1);
        chk("R10 disabled", {io_dec_en, mem_dec_en}, 0);
        chk("R10 bases off", {io_base, mem_base, rom_base}, 0);
        chk("R10 pf off", pf_base, 0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        @(negedge clk); stat_evt = 8'hFF;
        @(negedge clk); stat_evt = 8'h00;
        rd(1, v); chk("R3 set", v, 32'hF900_0500);
        wr(1, 32'h0800_0000, 4'b1000); chk("R3 quiet", last_remap, 0);
        rd(1, v); chk("R3 clear one", v, 32'hF100_0500);
        wr(1, 32'h0, 4'b1000);
        rd(1, v); chk("R3 zero keeps", v, 32'hF100_0500);
        @(negedge clk);
        stat_evt = 8'h08; cfg_addr = 4'd1; wdata = 32'h0800_0000; be = 4'b1000; wr_en = 1'b1;
        @(negedge clk);
        stat_evt = 8'h00; wr_en = 1'b0; be = '0;
        rd(1, v); chk("R3 set wins", v, 32'hF900_0500);
        wr(1, 32'hFFFF_0000, 4'b1100);
        rd(1, v); chk("R4 w1c not writable", v, 32'h0000_0500);
    endtask

    task automatic t_read_latency();
        logic [31:0] v;
        rd(0, v); chk("R5 first", v, ID_W);
        @(negedge clk); cfg_addr = 4'd2; rd_en = 1'b1;
        chk("R5 before edge", rdata, ID_W);
        @(negedge clk); rd_en = 1'b0;
        chk("R5 after edge", rdata, CLS_W);
        cfg_addr = 4'd0;
        @(negedge clk); chk("R5 hold", rdata, CLS_W);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ids();
        t_merge();
        t_bar_size();
        t_remap();
        t_decode();
        t_w1c();
        t_read_latency();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule